// File: doc/BRIEF.md
# Length-Prefixed Serial Receive Packetizer

This block sits between the byte output of a serial receiver and a byte stream that goes back to a host. A command turns it on or off. While it is on, every received byte goes into a small buffer. The buffered bytes leave as packets. Each packet starts with a header byte that carries its payload length, so the host can always tell a reply to a command from received data.

A packet holds 1 to 16 payload bytes. The block sends one when 16 bytes are waiting. It also sends one when no byte has arrived for a programmable number of cycles and at least one byte is waiting. Every mode command is answered with a single acknowledge byte. That acknowledge never breaks into a packet that is already on its way. Turning the block off first drains the buffer as packets and then sends the acknowledge.

When the buffer is full, a new byte is dropped and a sticky overflow flag is raised on a port.

Top module: `rx_packet_framer`

## Requirements
- R1: After reset, `out_valid` and `overflow` are low, and packetizing is off.
- R2: A command byte matching binary 0000010x sets packetizing on when bit 0 is 1 and off when bit 0 is 0. Each such command is answered by exactly one output byte, 0x01.
- R3: Any other command byte value produces no output and does not change the on/off mode.
- R4: While packetizing is off, received bytes are discarded and produce no output.
- R5: Each packet is one header byte with bits [7:4] = 0001 and bits [3:0] = payload count minus one. The header is followed by exactly that many payload bytes (1 to 16), in arrival order.
- R6: When 16 received bytes are waiting and the block is free, it starts a packet of 16.
- R7: When bytes are waiting and none arrives, the header of a packet holding all waiting bytes (at most 16) is presented after the (`idle_limit`+1)th rising edge that follows the edge that captured the last byte.
- R8: Once a header has been presented, `out_valid` stays high until the last payload byte of that packet is taken. While `out_valid` is high and `out_ready` is low, `out_byte` holds its value.
- R9: A mode acknowledge is held until the packet in progress is complete. An enable acknowledge is not held back by waiting bytes that are not yet in a packet.
- R10: On disable, all waiting bytes go out as packets of at most 16 bytes before the 0x01 acknowledge. Bytes received after the disable command are discarded.
- R11: A byte that arrives while the buffer holds DEPTH bytes is dropped. This sets `overflow`, which stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_limit | input | IDLE_W | Idle cycles before a partial packet is sent |
| cmd_byte | input | 8 | Command byte from the host |
| cmd_valid | input | 1 | Command byte strobe |
| rx_byte | input | 8 | Byte from the serial receiver |
| rx_valid | input | 1 | Received byte strobe |
| out_ready | input | 1 | Host accepts the output byte this cycle |
| out_byte | output | 8 | Output byte (acknowledge, header or payload) |
| out_valid | output | 1 | Output byte is valid |
| overflow | output | 1 | Sticky flag: a received byte was dropped |

## Verification
The assertions assume that the host sends a mode command only after the acknowledge to the previous one has been taken. The command-spacing check enforces this. They also assume `idle_limit` does not change while bytes are waiting.

The stimulus follows both rules:
- It waits for the output queue of its reference model to drain before each new mode command.
- It programs `idle_limit` once, during reset.

Bursts are sized and placed so that packet boundaries follow from the requirements alone:
- Gaps between bursts are well beyond the idle limit.
- Back-pressure phases are either fully stalled or kept short enough not to overflow the buffer, except in the one test that provokes the overflow on purpose.

// File: rtl/rxpk_pkg.sv
`timescale 1ns/1ps
package rxpk_pkg;
  localparam logic [7:0] ACK_BYTE = 8'h01;
  localparam logic [3:0] HDR_TAG  = 4'h1;
  localparam logic [6:0] MODE_CMD = 7'b0000010;

  typedef enum logic {ST_IDLE, ST_PAY} fr_state_t;
endpackage

// File: rtl/rxpk_fifo.sv
`timescale 1ns/1ps
module rxpk_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 32
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [W-1:0]               wr_data,
  input  logic                       rd_en,
  output logic [W-1:0]               rd_data,
  output logic [$clog2(DEPTH+1)-1:0] count,
  output logic                       full,
  output logic                       empty
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= wr_data;
  end

  assign rd_data = mem[rd_ptr];
  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (wr_en) wr_ptr <= bump(wr_ptr);
      if (rd_en) rd_ptr <= bump(rd_ptr);
      case ({wr_en, rd_en})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end

  // R11
  fifo_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !full);
  // R5
  fifo_no_underrun_chk: assert property (@(posedge clk) disable iff (rst)
    rd_en |-> !empty);
  // R11
  fifo_count_bound_chk: assert property (@(posedge clk) disable iff (rst)
    count <= CW'(DEPTH));
endmodule

// File: rtl/rxpk_idle_timer.sv
`timescale 1ns/1ps
module rxpk_idle_timer #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  input  logic          active,
  input  logic [CW-1:0] limit,
  output logic          expired
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || restart || !active) cnt <= '0;
    else if (cnt != '1)            cnt <= cnt + CW'(1);
  end

  assign expired = active && (cnt >= limit);
endmodule

// File: rtl/rx_packet_framer.sv
`timescale 1ns/1ps
module rx_packet_framer import rxpk_pkg::*; #(
  parameter int DEPTH   = 32,
  parameter int MAX_PKT = 16,
  parameter int IDLE_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDLE_W-1:0] idle_limit,
  input  logic [7:0]        cmd_byte,
  input  logic              cmd_valid,
  input  logic [7:0]        rx_byte,
  input  logic              rx_valid,
  input  logic              out_ready,
  output logic [7:0]        out_byte,
  output logic              out_valid,
  output logic              overflow
);
  localparam int CNT_W = $clog2(DEPTH+1);
  localparam int LEN_W = $clog2(MAX_PKT+1);

  fr_state_t         st;
  logic              enabled, ack_pend, ack_off;
  logic [LEN_W-1:0]  remain, plen, plen_m1;
  logic [CNT_W-1:0]  count;
  logic [7:0]        rd_data;
  logic              full, empty, expired;
  logic              cmd_hit, push, pop, can_load, flush_req, ack_go, pkt_go;

  assign cmd_hit   = cmd_valid && (cmd_byte[7:1] == MODE_CMD);
  assign push      = rx_valid && enabled && !full;
  assign can_load  = !out_valid || out_ready;
  assign pop       = (st == ST_PAY) && can_load;
  assign flush_req = ack_pend && ack_off;
  assign ack_go    = ack_pend && (!ack_off || empty);
  assign pkt_go    = !empty && (flush_req ||
                     (enabled && ((count >= CNT_W'(MAX_PKT)) || expired)));
  assign plen      = (count >= CNT_W'(MAX_PKT)) ? LEN_W'(MAX_PKT) : LEN_W'(count);
  assign plen_m1   = plen - LEN_W'(1);

  rxpk_fifo #(.W(8), .DEPTH(DEPTH)) buf_i (
    .clk(clk), .rst(rst), .wr_en(push), .wr_data(rx_byte),
    .rd_en(pop), .rd_data(rd_data), .count(count), .full(full), .empty(empty)
  );

  rxpk_idle_timer #(.CW(IDLE_W)) idle_i (
    .clk(clk), .rst(rst), .restart(push), .active(!empty),
    .limit(idle_limit), .expired(expired)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= ST_IDLE;
      enabled   <= 1'b0;
      ack_pend  <= 1'b0;
      ack_off   <= 1'b0;
      overflow  <= 1'b0;
      remain    <= '0;
      out_byte  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (rx_valid && enabled && full) overflow <= 1'b1;
      case (st)
        ST_IDLE: if (can_load) begin
          if (ack_go) begin
            out_byte  <= ACK_BYTE;
            out_valid <= 1'b1;
            ack_pend  <= 1'b0;
          end else if (pkt_go) begin
            out_byte  <= {HDR_TAG, 4'(plen_m1)};
            out_valid <= 1'b1;
            remain    <= plen;
            st        <= ST_PAY;
          end else begin
            out_valid <= 1'b0;
          end
        end
        ST_PAY: if (can_load) begin
          out_byte  <= rd_data;
          out_valid <= 1'b1;
          remain    <= remain - LEN_W'(1);
          if (remain == LEN_W'(1)) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
      if (cmd_hit) begin
        enabled  <= cmd_byte[0];
        ack_pend <= 1'b1;
        ack_off  <= !cmd_byte[0];
      end
    end
  end

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte)));
  // R11
  ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R5
  hdr_form_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PAY && $past(st) == ST_IDLE) |-> (out_valid && out_byte[7:4] == HDR_TAG));
  // R6
  full_trigger_chk: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && can_load && !ack_pend && enabled && count >= CNT_W'(MAX_PKT))
      |=> (st == ST_PAY && remain == LEN_W'(MAX_PKT)));
  // R2: input expectation, one outstanding mode command at a time
  cmd_spacing_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_hit |-> !ack_pend);
endmodule

// File: tb/rx_packet_framer_tb.sv
`timescale 1ns/1ps
module rx_packet_framer_tb_top;
  localparam int IDLE = 20;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [15:0] idle_limit = 16'(IDLE);
  logic [7:0] cmd_byte = '0;
  logic       cmd_valid = 1'b0;
  logic [7:0] rx_byte = '0;
  logic       rx_valid = 1'b0;
  logic       out_ready = 1'b1;
  logic [7:0] out_byte;
  logic       out_valid;
  logic       overflow;

  logic       ready_base = 1'b1;
  logic       stall_en = 1'b0;
  logic [7:0] lfsr = 8'hA5;

  int checks = 0;
  int fails = 0;
  int rx_idx = 0;
  int pkt_left = 0;
  logic [7:0] q_exp[$];
  int         q_kind[$];

  always #2.5 clk = ~clk;

  rx_packet_framer dut_i (
    .clk(clk), .rst(rst), .idle_limit(idle_limit),
    .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .out_ready(out_ready),
    .out_byte(out_byte), .out_valid(out_valid), .overflow(overflow)
  );

  function automatic logic [7:0] dval(input int i);
    return 8'((i * 37 + 11) & 255);
  endfunction

  always @(negedge clk) begin
    lfsr <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    out_ready <= stall_en ? lfsr[0] : ready_base;
  end

  // reference model: ordered queue of expected output bytes, checked every cycle
  always @(negedge clk) begin
    #1.5;
    if (!rst) begin
      if (pkt_left > 0) begin
        checks++;
        if (!out_valid) begin
          fails++;
          $display("FAIL R8: gap inside packet, out_valid=%0b expected 1", out_valid);
        end
      end
      if (out_valid && out_ready) begin
        checks++;
        if (q_exp.size() == 0) begin
          fails++;
          $display("FAIL R5: unexpected byte %h, expected none", out_byte);
        end else begin
          logic [7:0] eb;
          int ek;
          eb = q_exp.pop_front();
          ek = q_kind.pop_front();
          if (out_byte !== eb) begin
            fails++;
            $display("FAIL %s: got %h expected %h", (ek == 0) ? "R2" : "R5", out_byte, eb);
          end
          if (ek == 1) pkt_left = int'(eb[3:0]) + 1;
          else if (ek == 2) pkt_left--;
        end
      end
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic exp_ack();
    q_exp.push_back(8'h01); q_kind.push_back(0);
  endtask

  task automatic exp_burst(input int first, input int n);
    int left = n;
    int idx = first;
    while (left > 0) begin
      int len = (left > 16) ? 16 : left;
      q_exp.push_back(8'h10 | 8'(len - 1)); q_kind.push_back(1);
      for (int i = 0; i < len; i++) begin
        q_exp.push_back(dval(idx)); q_kind.push_back(2);
        idx++;
      end
      left -= len;
    end
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk); cmd_byte = b; cmd_valid = 1'b1;
    @(negedge clk); cmd_valid = 1'b0;
  endtask

  task automatic send_rx(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); rx_byte = dval(rx_idx); rx_valid = 1'b1;
      rx_idx++;
    end
    @(negedge clk); rx_valid = 1'b0;
  endtask

  task automatic wait_drain(input string tag);
    int t = 0;
    while ((q_exp.size() != 0 || out_valid) && t < 3000) begin
      @(negedge clk); t++;
    end
    check(tag, q_exp.size(), 0);
  endtask

  task automatic quiet_window(input string tag, input int n);
    logic seen = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (out_valid) seen = 1'b1;
    end
    check(tag, seen, 1'b0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int first;
    int cnt;
    repeat (6) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check("R1", out_valid, 1'b0);
    check("R1", overflow, 1'b0);

    // R4: off after reset, received bytes vanish
    send_rx(4);
    quiet_window("R4", 60);

    // R3: unrelated command values are not mode commands
    send_cmd(8'h06);
    send_cmd(8'h0C);
    send_rx(3);
    quiet_window("R3", 60);

    // R2: enable command acknowledged with 0x01
    exp_ack();
    send_cmd(8'h05);
    wait_drain("R2");

    // R7: idle timeout latency
    first = rx_idx;
    exp_burst(first, 3);
    send_rx(3);
    cnt = 0;
    while (cnt < 200) begin
      @(posedge clk); cnt++;
      @(negedge clk);
      if (out_valid) break;
    end
    check("R7", cnt, IDLE + 1);
    wait_drain("R7");

    // R6: long burst splits into full packets plus remainder
    first = rx_idx;
    exp_burst(first, 40);
    send_rx(40);
    wait_drain("R6");

    // R9: enable acknowledge goes before a not-yet-formed packet
    first = rx_idx;
    exp_ack();
    exp_burst(first, 3);
    send_rx(3);
    send_cmd(8'h05);
    wait_drain("R9");

    // R8: random back-pressure
    stall_en = 1'b1;
    first = rx_idx;
    exp_burst(first, 24);
    send_rx(24);
    wait_drain("R8");
    stall_en = 1'b0;
    repeat (4) @(negedge clk);

    // R10 and R9: disable while a packet is stalled, flush then acknowledge
    ready_base = 1'b0;
    first = rx_idx;
    exp_burst(first, 20);
    exp_ack();
    send_rx(20);
    send_cmd(8'h04);
    repeat (5) @(negedge clk);
    ready_base = 1'b1;
    wait_drain("R10");
    send_rx(3);
    quiet_window("R10", 60);
    check("R11", overflow, 1'b0);

    // R11: overflow drops bytes beyond the buffer and sticks
    exp_ack();
    send_cmd(8'h05);
    wait_drain("R2");
    ready_base = 1'b0;
    first = rx_idx;
    exp_burst(first, 32);
    send_rx(40);
    repeat (5) @(negedge clk);
    check("R11", overflow, 1'b1);
    ready_base = 1'b1;
    wait_drain("R11");
    first = rx_idx;
    exp_burst(first, 2);
    send_rx(2);
    wait_drain("R5");
    check("R11", overflow, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule